// File: doc/BRIEF.md
# Sub-Word Load/Store Unit with Link Reservation

This unit performs the data-memory side of a 32-bit core's loads and stores. Each request carries a base register value, a signed 16-bit displacement, an access size and a kind (plain load, plain store, linked load, conditional store). The unit forms the effective address, drives a word-wide synchronous memory with per-byte write enables, and one cycle later returns the load value, narrowed to the addressed byte or half-word and widened to 32 bits with either sign or zero fill.

A single reservation supports atomic read-modify-write sequences. A linked load records the word it read. A later conditional store writes memory only while that record is still intact, and it returns 1 (success) or 0 (failure) as its result. Writes by other agents reach the unit through a snoop port, and any write to the reserved word, whether snooped or local, breaks the reservation. Misaligned half-word and word accesses are refused and flagged.

Top module: `lsu_core`

## Requirements
- R1: The effective address is `req_base` plus `req_disp` sign-extended to 32 bits. `mem_addr` carries effective-address bits [ADDR_W+1:2].
- R2: `done` is high in the cycle after every cycle in which `req_valid` is high, and low otherwise. `rdata` and `misalign` are valid while `done` is high. Requests may be issued back to back.
- R3: `req_kind` 0 is a load. `req_size` 0 selects a byte in lane EA[1:0], 1 selects a half-word at lanes {EA[1],0} and {EA[1],1}, and 2 or 3 selects the full word. Byte lane k is data bits [8k+7:8k]. With `req_unsigned`=1 a byte or half-word is zero-filled. With `req_unsigned`=0 its top bit is replicated.
- R4: `req_kind` 1 is a store. A byte store writes `req_wdata[7:0]` into lane EA[1:0] only. A half-word store writes `req_wdata[15:0]` into its two lanes only. A word store writes all four lanes. The result of a store is 0.
- R5: A half-word access with EA[0]=1, or a word, linked-load or conditional-store access with EA[1:0]≠0, gives `misalign`=1 and `rdata`=0. It does not enable memory and leaves the reservation untouched.
- R6: `req_kind` 2 is a linked load. It always reads the full word, whatever `req_size` is. It returns that word and reserves the word address.
- R7: `req_kind` 3 is a conditional store. It succeeds when the reservation is valid, holds the same word address, and no snoop write to that word occurs in the same cycle. On success it writes all of `req_wdata` and returns 1.
- R8: A conditional store that does not succeed writes nothing and returns 0. This covers the case with no reservation and the case of a different word.
- R9: A snoop write (`snoop_valid`, byte address `snoop_addr`) to the reserved word clears the reservation. A snoop to the same word in the same cycle as a linked load leaves no reservation. Snoops to other words have no effect.
- R10: An aligned plain store to the reserved word clears the reservation. A store to another word does not.
- R11: Every aligned conditional store clears the reservation, whether it succeeds or fails.
- R12: After reset `done` and `misalign` are 0 and no reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 load, 1 store, 2 linked load, 3 conditional store |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| req_unsigned | input | 1 | Zero-fill narrow loads |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| snoop_valid | input | 1 | Another agent writes memory this cycle |
| snoop_addr | input | 32 | Byte address of the snooped write |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write |
| mem_be | output | 4 | Byte-lane write enables |
| mem_addr | output | ADDR_W | Memory word index |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Memory read word, one cycle after address |
| done | output | 1 | Result cycle |
| misalign | output | 1 | Alignment fault for the finished request |
| rdata | output | 32 | Extended load value or conditional-store result |

## Verification
The hardest situations to reach are the races around the reservation: a snoop to the reserved word in the very cycle of the conditional store or of the linked load, and a misaligned linked or conditional access that must leave the reservation alone. The bench drives the snoop port in the same cycle as the request to create these races. It follows each conditional store with a word load, so that both the returned flag and the memory contents are checked.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int XLEN  = 32;
    localparam int LANES = XLEN / 8;
    localparam int OFS_W = $clog2(LANES);
    localparam int WA_W  = XLEN - OFS_W;

    typedef enum logic [1:0] {
        K_LOAD  = 2'd0,
        K_STORE = 2'd1,
        K_LINK  = 2'd2,
        K_COND  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        SZ_B  = 2'd0,
        SZ_H  = 2'd1,
        SZ_W  = 2'd2,
        SZ_WX = 2'd3
    } size_e;

    typedef struct packed {
        logic             busy;
        kind_e            kind;
        size_e            size;
        logic             uns;
        logic [OFS_W-1:0] ofs;
        logic             bad;
        logic             sc_ok;
    } stage_t;

    typedef struct packed {
        logic            valid;
        logic [WA_W-1:0] word;
    } resv_t;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int DISP_W = 16
) (
    input  logic [XLEN-1:0]   base,
    input  logic [DISP_W-1:0] disp,
    input  kind_e             kind,
    input  size_e             size,
    input  logic [XLEN-1:0]   sd,
    output logic [XLEN-1:0]   ea,
    output size_e             eff_size,
    output logic              bad,
    output logic [LANES-1:0]  be,
    output logic [XLEN-1:0]   wdata
);
    always_comb begin
        ea = base + {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
        if (kind == K_LINK || kind == K_COND || size == SZ_WX)
            eff_size = SZ_W;
        else
            eff_size = size;
        case (eff_size)
            SZ_B: begin
                bad   = 1'b0;
                be    = LANES'(1) << ea[OFS_W-1:0];
                wdata = {LANES{sd[7:0]}};
            end
            SZ_H: begin
                bad   = ea[0];
                be    = LANES'(3) << {ea[OFS_W-1:1], 1'b0};
                wdata = {(LANES/2){sd[15:0]}};
            end
            default: begin
                bad   = |ea[OFS_W-1:0];
                be    = '1;
                wdata = sd;
            end
        endcase
    end
endmodule

// File: rtl/lsu_resv.sv
module lsu_resv
    import lsu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ll_fire,
    input  logic            sc_fire,
    input  logic            st_fire,
    input  logic [WA_W-1:0] acc_word,
    input  logic            snoop_valid,
    input  logic [WA_W-1:0] snoop_word,
    output logic            sc_ok
);
    resv_t rs_d, rs_q;
    logic  snoop_hits_acc;

    always_comb begin
        snoop_hits_acc = snoop_valid && (snoop_word == acc_word);
        sc_ok = sc_fire && rs_q.valid && (rs_q.word == acc_word) && !snoop_hits_acc;
        rs_d = rs_q;
        if (snoop_valid && snoop_word == rs_q.word)
            rs_d.valid = 1'b0;
        if (st_fire && acc_word == rs_q.word)
            rs_d.valid = 1'b0;
        if (sc_fire)
            rs_d.valid = 1'b0;
        if (ll_fire) begin
            rs_d.valid = !snoop_hits_acc;
            rs_d.word  = acc_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assert_sc_needs_resv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_fire && !rs_q.valid) |-> !sc_ok);
    assert_sc_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_fire && !ll_fire) |=> !rs_q.valid);
    assert_snoop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && rs_q.valid && snoop_word == rs_q.word && !ll_fire) |=> !rs_q.valid);
endmodule

// File: rtl/lsu_extend.sv
module lsu_extend
    import lsu_pkg::*;
(
    input  logic [XLEN-1:0]  raw,
    input  size_e            size,
    input  logic             uns,
    input  logic [OFS_W-1:0] ofs,
    output logic [XLEN-1:0]  value
);
    logic [XLEN-1:0] sh_b, sh_h;

    always_comb begin
        sh_b = raw >> {ofs, 3'b000};
        sh_h = raw >> {ofs[OFS_W-1:1], 4'b0000};
        case (size)
            SZ_B:    value = uns ? {{(XLEN-8){1'b0}}, sh_b[7:0]}
                                 : {{(XLEN-8){sh_b[7]}}, sh_b[7:0]};
            SZ_H:    value = uns ? {{(XLEN-16){1'b0}}, sh_h[15:0]}
                                 : {{(XLEN-16){sh_h[15]}}, sh_h[15:0]};
            default: value = raw;
        endcase
    end
endmodule

// File: rtl/lsu_core.sv
module lsu_core
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [XLEN-1:0]   req_base,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [XLEN-1:0]   req_wdata,
    input  logic              snoop_valid,
    input  logic [XLEN-1:0]   snoop_addr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [LANES-1:0]  mem_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              done,
    output logic              misalign,
    output logic [XLEN-1:0]   rdata
);
    kind_e           kind;
    size_e           eff_size;
    logic [XLEN-1:0] ea, wdata, ext_val;
    logic [LANES-1:0] be;
    logic            bad, fire, sc_ok;
    stage_t          st_d, st_q;

    assign kind = kind_e'(req_kind);

    lsu_agen #(.DISP_W(DISP_W)) u_agen (
        .base(req_base), .disp(req_disp), .kind(kind), .size(size_e'(req_size)),
        .sd(req_wdata), .ea(ea), .eff_size(eff_size), .bad(bad), .be(be), .wdata(wdata)
    );

    assign fire = req_valid && !bad;

    lsu_resv u_resv (
        .clk(clk), .rst_n(rst_n),
        .ll_fire(fire && kind == K_LINK),
        .sc_fire(fire && kind == K_COND),
        .st_fire(fire && kind == K_STORE),
        .acc_word(ea[XLEN-1:OFS_W]),
        .snoop_valid(snoop_valid),
        .snoop_word(snoop_addr[XLEN-1:OFS_W]),
        .sc_ok(sc_ok)
    );

    always_comb begin
        mem_en    = fire && (kind != K_COND || sc_ok);
        mem_we    = mem_en && (kind == K_STORE || kind == K_COND);
        mem_be    = mem_we ? be : '0;
        mem_addr  = ea[ADDR_W+OFS_W-1:OFS_W];
        mem_wdata = wdata;
        st_d.busy  = req_valid;
        st_d.kind  = kind;
        st_d.size  = eff_size;
        st_d.uns   = req_unsigned;
        st_d.ofs   = ea[OFS_W-1:0];
        st_d.bad   = req_valid && bad;
        st_d.sc_ok = sc_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lsu_extend u_ext (
        .raw(mem_rdata), .size(st_q.size), .uns(st_q.uns), .ofs(st_q.ofs), .value(ext_val)
    );

    always_comb begin
        done     = st_q.busy;
        misalign = st_q.busy && st_q.bad;
        rdata    = '0;
        if (st_q.busy && !st_q.bad) begin
            case (st_q.kind)
                K_LOAD, K_LINK: rdata = ext_val;
                K_COND:         rdata = {{(XLEN-1){1'b0}}, st_q.sc_ok};
                default:        rdata = '0;
            endcase
        end
    end

    assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);
    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done);
    assert_misalign_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad) |-> !mem_en);
    assert_byte_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && eff_size == SZ_B) |-> $countones(mem_be) == 1);
    assert_write_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);
endmodule

// File: tb/sim_lsu_core.sv
`timescale 1ns/1ps
module sim_lsu_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        req_valid = 1'b0, req_unsigned = 1'b0, snoop_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0, req_size = 2'd0;
    logic [31:0] req_base = '0, req_wdata = '0, snoop_addr = '0, snoop_wdata = '0;
    logic [15:0] req_disp = '0;
    logic        mem_en, mem_we, done, misalign;
    logic [3:0]  mem_be;
    logic [9:0]  mem_addr;
    logic [31:0] mem_wdata, mem_rdata, rdata;

    lsu_core u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
        .req_disp(req_disp), .req_wdata(req_wdata), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .misalign(misalign), .rdata(rdata)
    );

    logic [31:0] mem [0:1023];
    logic [31:0] ref_mem [0:1023];

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we)
                for (int l = 0; l < 4; l++)
                    if (mem_be[l]) mem[mem_addr][8*l +: 8] <= mem_wdata[8*l +: 8];
            mem_rdata <= mem[mem_addr];
        end
        if (snoop_valid) mem[snoop_addr[11:2]] <= snoop_wdata;
    end

    int tests = 0, fails = 0;
    logic [31:0] g_rd;
    logic        g_done, g_mis;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic acc(input logic [1:0] kind, input logic [1:0] size, input logic uns,
                       input logic [31:0] base, input logic [15:0] disp, input logic [31:0] wd,
                       input logic sv, input logic [31:0] sa, input logic [31:0] sdat);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_size = size; req_unsigned = uns;
        req_base = base; req_disp = disp; req_wdata = wd;
        snoop_valid = sv; snoop_addr = sa; snoop_wdata = sdat;
        @(negedge clk);
        g_rd = rdata; g_done = done; g_mis = misalign;
        req_valid = 1'b0; snoop_valid = 1'b0;
    endtask

    task automatic snoop_only(input logic [31:0] sa, input logic [31:0] sdat);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_addr = sa; snoop_wdata = sdat;
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    task automatic load_word(input int w, input string req);
        acc(2'd0, 2'd2, 1'b0, w*4, 16'd0, 32'd0, 1'b0, 32'd0, 32'd0);
        chk(req, g_rd, ref_mem[w]);
    endtask

    function automatic logic [31:0] ld_exp(input logic [31:0] w, input int ofs, input int sz,
                                           input logic uns);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[8*ofs +: 8];
        h = w[8*(ofs & 2) +: 16];
        if (sz == 0) return uns ? {24'd0, b} : {{24{b[7]}}, b};
        if (sz == 1) return uns ? {16'd0, h} : {{16{h[15]}}, h};
        return w;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i] = (i * 32'h0102_0305) ^ 32'h8A5C_39E7;
            ref_mem[i] = mem[i];
        end
        mem_rdata = '0;
        repeat (3) @(negedge clk);
        chk("R12 done after reset", {31'd0, done}, 32'd0);
        chk("R12 misalign after reset", {31'd0, misalign}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 done idle", {31'd0, done}, 32'd0);
        acc(2'd3, 2'd2, 1'b0, 32'd40, 16'd0, 32'hDEAD_0001, 1'b0, 0, 0);
        chk("R12 no reservation: sc result", g_rd, 32'd0);
        load_word(10, "R12 no write by first sc");

        // R1 word loads through negative displacement
        for (int w = 0; w < 16; w++) begin
            acc(2'd0, 2'd2, 1'b0, w*4 + 200, 16'hFF38, 0, 1'b0, 0, 0);
            chk("R1 negative displacement word load", g_rd, ref_mem[w]);
            chk("R2 done with result", {31'd0, g_done}, 32'd1);
        end

        // R3 sub-word load sweep
        for (int w = 0; w < 8; w++)
            for (int o = 0; o < 4; o++)
                for (int sz = 0; sz < 2; sz++)
                    for (int u = 0; u < 2; u++) begin
                        if (sz == 1 && (o % 2) == 1) continue;
                        acc(2'd0, sz[1:0], u[0], 32'd8, 16'(w*4 + o - 8), 0, 1'b0, 0, 0);
                        chk("R3 narrow load extension", g_rd, ld_exp(ref_mem[w], o, sz, u[0]));
                    end

        // R2 back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_size = 2'd2; req_base = 32'd4; req_disp = 0;
        @(negedge clk);
        chk("R2 first of pair", rdata, ref_mem[1]);
        req_base = 32'd8;
        @(negedge clk);
        chk("R2 second of pair", rdata, ref_mem[2]);
        chk("R2 done held", {31'd0, done}, 32'd1);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 done drops", {31'd0, done}, 32'd0);

        // R4 stores of every width
        for (int w = 16; w < 24; w++) begin
            for (int o = 0; o < 4; o++) begin
                acc(2'd1, 2'd0, 1'b0, w*4 + o, 16'd0, 32'h1234_5600 + 32'(w*8 + o), 1'b0, 0, 0);
                ref_mem[w][8*o +: 8] = 8'(w*8 + o);
                chk("R4 store result zero", g_rd, 32'd0);
            end
            load_word(w, "R4 byte store lanes");
            acc(2'd1, 2'd1, 1'b0, w*4 + 2, 16'd0, 32'hFFFF_0000 | 32'(w*77), 1'b0, 0, 0);
            ref_mem[w][31:16] = 16'(w*77);
            load_word(w, "R4 half store upper lanes");
            acc(2'd1, 2'd2, 1'b0, w*4, 16'd0, 32'hC001_0000 + 32'(w), 1'b0, 0, 0);
            ref_mem[w] = 32'hC001_0000 + 32'(w);
            load_word(w, "R4 word store");
        end

        // R5 misaligned accesses
        for (int o = 1; o < 4; o++) begin
            acc(2'd0, 2'd2, 1'b0, 25*4 + o, 16'd0, 0, 1'b0, 0, 0);
            chk("R5 word load misalign flag", {31'd0, g_mis}, 32'd1);
            chk("R5 misaligned result zero", g_rd, 32'd0);
            acc(2'd1, 2'd2, 1'b0, 25*4 + o, 16'd0, 32'hBAD0_BAD0, 1'b0, 0, 0);
            chk("R5 word store misalign flag", {31'd0, g_mis}, 32'd1);
            if (o % 2 == 1) begin
                acc(2'd1, 2'd1, 1'b0, 25*4 + o, 16'd0, 32'hBAD1_BAD1, 1'b0, 0, 0);
                chk("R5 half store misalign flag", {31'd0, g_mis}, 32'd1);
            end
        end
        load_word(25, "R5 memory untouched by misaligned stores");
        acc(2'd0, 2'd0, 1'b0, 25*4 + 1, 16'd0, 0, 1'b0, 0, 0);
        chk("R5 byte access never misaligned", {31'd0, g_mis}, 32'd0);
        acc(2'd3, 2'd2, 1'b0, 50*4, 16'd0, 32'h5, 1'b0, 0, 0);
        acc(2'd2, 2'd2, 1'b0, 50*4 + 2, 16'd0, 0, 1'b0, 0, 0);
        chk("R5 misaligned link flagged", {31'd0, g_mis}, 32'd1);
        acc(2'd3, 2'd2, 1'b0, 50*4, 16'd0, 32'h5, 1'b0, 0, 0);
        chk("R5 misaligned link leaves no reservation", g_rd, 32'd0);
        acc(2'd2, 2'd2, 1'b0, 51*4, 16'd0, 0, 1'b0, 0, 0);
        acc(2'd3, 2'd2, 1'b0, 51*4 + 1, 16'd0, 32'h77, 1'b0, 0, 0);
        chk("R5 misaligned cond store flagged", {31'd0, g_mis}, 32'd1);
        acc(2'd3, 2'd2, 1'b0, 51*4, 16'd0, 32'h7777_0051, 1'b0, 0, 0);
        chk("R5 reservation kept across misaligned cond store", g_rd, 32'd1);
        ref_mem[51] = 32'h7777_0051;
        load_word(51, "R7 word written on success");

        // R6 / R7 / R11 basic sequence
        acc(2'd2, 2'd0, 1'b0, 30*4, 16'd0, 0, 1'b0, 0, 0);
        chk("R6 link returns full word", g_rd, ref_mem[30]);
        acc(2'd3, 2'd0, 1'b0, 30*4, 16'd0, 32'hA1B2_C3D4, 1'b0, 0, 0);
        chk("R7 cond store success flag", g_rd, 32'd1);
        ref_mem[30] = 32'hA1B2_C3D4;
        load_word(30, "R7 cond store wrote word");
        acc(2'd3, 2'd2, 1'b0, 30*4, 16'd0, 32'h0BAD_0BAD, 1'b0, 0, 0);
        chk("R11 second cond store fails", g_rd, 32'd0);
        load_word(30, "R8 failed cond store no write");

        // R9 snoop in an idle cycle
        acc(2'd2, 2'd2, 1'b0, 31*4, 16'd0, 0, 1'b0, 0, 0);
        snoop_only(31*4 + 3, 32'h5100_0031);
        ref_mem[31] = 32'h5100_0031;
        acc(2'd3, 2'd2, 1'b0, 31*4, 16'd0, 32'hEEEE_EEEE, 1'b0, 0, 0);
        chk("R9 snoop to reserved word fails cond store", g_rd, 32'd0);
        load_word(31, "R9 memory holds snooped value");
        acc(2'd2, 2'd2, 1'b0, 32*4, 16'd0, 0, 1'b0, 0, 0);
        snoop_only(33*4, 32'h5100_0033);
        ref_mem[33] = 32'h5100_0033;
        acc(2'd3, 2'd2, 1'b0, 32*4, 16'd0, 32'h3232_3232, 1'b0, 0, 0);
        chk("R9 snoop elsewhere keeps reservation", g_rd, 32'd1);
        ref_mem[32] = 32'h3232_3232;
        load_word(32, "R7 write after unrelated snoop");

        // R8 different word
        acc(2'd2, 2'd2, 1'b0, 34*4, 16'd0, 0, 1'b0, 0, 0);
        acc(2'd3, 2'd2, 1'b0, 35*4, 16'd0, 32'h3535_3535, 1'b0, 0, 0);
        chk("R8 cond store to other word fails", g_rd, 32'd0);
        load_word(35, "R8 other word unchanged");

        // R10 local stores
        acc(2'd2, 2'd2, 1'b0, 36*4, 16'd0, 0, 1'b0, 0, 0);
        acc(2'd1, 2'd0, 1'b0, 36*4 + 2, 16'd0, 32'h0000_0099, 1'b0, 0, 0);
        ref_mem[36][23:16] = 8'h99;
        acc(2'd3, 2'd2, 1'b0, 36*4, 16'd0, 32'h3636_3636, 1'b0, 0, 0);
        chk("R10 local byte store breaks reservation", g_rd, 32'd0);
        load_word(36, "R10 memory keeps byte store only");
        acc(2'd2, 2'd2, 1'b0, 37*4, 16'd0, 0, 1'b0, 0, 0);
        acc(2'd1, 2'd2, 1'b0, 38*4, 16'd0, 32'h3838_3838, 1'b0, 0, 0);
        ref_mem[38] = 32'h3838_3838;
        acc(2'd3, 2'd2, 1'b0, 37*4, 16'd0, 32'h3737_3737, 1'b0, 0, 0);
        chk("R10 store elsewhere keeps reservation", g_rd, 32'd1);
        ref_mem[37] = 32'h3737_3737;
        load_word(37, "R10 cond store wrote");

        // R9 same-cycle races
        acc(2'd2, 2'd2, 1'b0, 39*4, 16'd0, 0, 1'b0, 0, 0);
        acc(2'd3, 2'd2, 1'b0, 39*4, 16'd0, 32'h3939_3939, 1'b1, 39*4, 32'h5100_0039);
        chk("R9 snoop in cond store cycle fails it", g_rd, 32'd0);
        ref_mem[39] = 32'h5100_0039;
        load_word(39, "R9 snooped value survives");
        acc(2'd2, 2'd2, 1'b0, 40*4, 16'd0, 0, 1'b1, 40*4 + 1, 32'h5100_0040);
        ref_mem[40] = 32'h5100_0040;
        acc(2'd3, 2'd2, 1'b0, 40*4, 16'd0, 32'h4040_4040, 1'b0, 0, 0);
        chk("R9 snoop in link cycle leaves no reservation", g_rd, 32'd0);
        load_word(40, "R9 link-cycle snoop value");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule